// File: doc/BRIEF.md
# Parallel Flash Erase Sequencer

This block sits on the host side of a parallel NOR-style flash. It takes one erase job at a time through a valid/ready handshake. A job asks either for a whole-chip erase or for a set of sectors, given as a bitmask. The block then drives the flash write bus through the unlock and set-up cycles and the erase command. In sector mode it appends one single-write sector command for each further selected sector. Once the device's acceptance window has closed, it reads the status bit repeatedly until the device reports completion, and it ends the job with a one-cycle done pulse and an error code.

Bus timing is reduced to one write strobe per `WR_CLKS` clocks. `bus_hold` lets other traffic on a shared bus stall the block. The device stops taking further sector commands if two of them are separated by `WIN_CLKS` clocks or more. The block watches that gap itself and gives up the job rather than send a late command, because a late command would be taken as a foreign command.

Controller states are ST_IDLE, ST_PRE, ST_CMD, ST_MORE, ST_SETTLE, ST_POLL_RD, ST_POLL_SMP, ST_POLL_GAP and ST_FINISH. Their transitions are:
- ST_IDLE goes to ST_PRE on a non-empty request, or straight to ST_FINISH on an empty one.
- ST_PRE steps through five writes, then goes to ST_CMD.
- ST_CMD goes to ST_MORE when sectors remain, or to ST_SETTLE otherwise.
- ST_MORE goes to ST_SETTLE after the last sector, or to ST_FINISH when the gap runs out.
- ST_SETTLE goes to ST_POLL_RD once the bus is quiet.
- ST_POLL_RD goes to ST_POLL_SMP when the read is issued.
- ST_POLL_SMP goes to ST_FINISH on completion or timeout, and to ST_POLL_GAP otherwise.
- ST_POLL_GAP goes back to ST_POLL_RD.
- ST_FINISH returns to ST_IDLE.

Top module: `flash_erase_ctrl`

## Requirements
- R1: `req_ready` is 1 only in the idle state. A request is taken when `req_valid` and `req_ready` are both 1, and `req_ready` stays 0 from the next cycle until after `done`.
- R2: Every non-empty job begins with five writes, as (address, data) pairs: (UNLOCK_A, AAh), (UNLOCK_B, 55h), (UNLOCK_A, 80h), (UNLOCK_A, AAh), (UNLOCK_B, 55h). With the defaults UNLOCK_A is 555h and UNLOCK_B is 2AAh.
- R3: In sector mode the sixth write is data 30h to the base address of the lowest selected sector, where sector i has base address i << SECT_SHIFT. Each further selected sector then gets exactly one write of 30h at its base address, in ascending index order, with no unlock writes between them.
- R4: Write strobes (`bus_we`, one cycle each) are at least WR_CLKS cycles apart. They are exactly WR_CLKS apart when `bus_hold` stays low.
- R5: When `bus_hold` is 1 at a rising clock edge, neither `bus_we` nor `bus_re` is 1 in the following cycle.
- R6: Two successive sector-command strobes are never WIN_CLKS or more cycles apart. If the next one cannot be issued in time, the block issues no further write or read, and it ends the job with `err` = 1 and `err_code` = 1.
- R7: In sector mode, the first status read follows the last sector-command strobe by at least WIN_CLKS cycles, with no write in between.
- R8: In chip mode (`req_chip` = 1) `req_mask` is ignored. The sixth write is (UNLOCK_A, 10h), and status reads go to address 0.
- R9: In sector mode, status reads go to the base address of the lowest selected sector. Successive reads are at least POLL_CLKS cycles apart. The job ends with `err_code` = 0 on the first read whose bit POLL_BIT (bit 7) is 1; the other data bits are ignored.
- R10: If POLL_MAX reads in a row have bit 7 = 0, the job ends after the last of them with `err` = 1 and `err_code` = 2.
- R11: A sector-mode request with `req_mask` = 0 produces no bus cycle. It ends with `err` = 1 and `err_code` = 3.
- R12: `done` is a pulse of exactly one cycle per job. `err` and `err_code` are valid with it and hold until the next request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Job request |
| req_ready | output | 1 | Block idle, request can be taken |
| req_chip | input | 1 | 1 = whole-chip erase |
| req_mask | input | NUM_SECT | Selected sectors, bit i = sector i |
| done | output | 1 | One-cycle end-of-job pulse |
| err | output | 1 | Job ended with an error |
| err_code | output | 2 | 0 ok, 1 window missed, 2 poll timeout, 3 empty job |
| bus_hold | input | 1 | Shared bus busy, stall new cycles |
| bus_we | output | 1 | Write strobe, one cycle |
| bus_re | output | 1 | Read strobe, one cycle |
| bus_addr | output | ADDR_W | Flash word address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, sampled one cycle after `bus_re` |

## Verification
Every sector bitmask from empty to all four sectors is tried. This separates correct ascending ordering, single-sector jobs, sparse masks and the empty-job rejection. Chip-mode jobs carry non-zero masks to show that the mask has no effect. The bus is stalled in three ways: stalls every third cycle stretch the pacing without breaking the window; a short stall right after the first sector command still fits inside it; a long one forces the window abort, which is different from a lone-sector job under the same stall. The status model completes after one read, after exactly POLL_MAX reads, or never, which tells success at the poll limit apart from a timeout one read later.

// File: rtl/fec_pkg.sv
package fec_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_CMD,
        ST_MORE,
        ST_SETTLE,
        ST_POLL_RD,
        ST_POLL_SMP,
        ST_POLL_GAP,
        ST_FINISH
    } fec_state_t;

    typedef enum logic [1:0] {
        FEC_OK      = 2'd0,
        FEC_LATE    = 2'd1,
        FEC_TIMEOUT = 2'd2,
        FEC_EMPTY   = 2'd3
    } fec_err_t;

endpackage

// File: rtl/fec_counter.sv
// Saturating up-counter with synchronous clear.
module fec_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != {W{1'b1}})) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fec_sector_pick.sv
// Finds the lowest selected sector and the mask without it.
module fec_sector_pick #(
    parameter int NUM_SECT = 4,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_SECT-1:0] mask,
    output logic [IDX_W-1:0]    idx,
    output logic [NUM_SECT-1:0] rest
);

    always_comb begin
        idx = '0;
        for (int i = NUM_SECT - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = IDX_W'(i);
            end
        end
        rest = mask & ~(NUM_SECT'(1) << idx);
    end

endmodule

// File: rtl/fec_bus_port.sv
// Paces flash bus cycles: one registered write strobe per WR_CLKS clocks,
// single-cycle reads, and a stall input from the shared bus.
module fec_bus_port #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 8,
    parameter int WR_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              wr_acc,
    output logic              rd_acc,
    output logic              busy,
    output logic              bus_we,
    output logic              bus_re,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);

    assign wr_acc = wr_req && !busy && !hold;
    assign rd_acc = rd_req && !wr_req && !busy && !hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_we    <= 1'b0;
            bus_re    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            bus_we <= wr_acc;
            bus_re <= rd_acc;
            if (wr_acc || rd_acc) begin
                bus_addr  <= req_addr;
                bus_wdata <= wr_acc ? req_data : '0;
            end
        end
    end

    generate
        if (WR_CLKS > 1) begin : g_pace
            localparam int BW = $clog2(WR_CLKS);
            logic [BW-1:0] left;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    left <= '0;
                end else if (wr_acc) begin
                    left <= BW'(WR_CLKS - 1);
                end else if (left != '0) begin
                    left <= left - 1'b1;
                end
            end

            assign busy = (left != '0);

            AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                bus_we |=> !bus_we); // R4
        end else begin : g_nopace
            assign busy = 1'b0;
        end
    endgenerate

    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !(bus_we || bus_re)); // R5

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re)); // R5

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import fec_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8,
    parameter int NUM_SECT   = 4,
    parameter int SECT_SHIFT = 10,
    parameter int WR_CLKS    = 4,
    parameter int WIN_CLKS   = 12,
    parameter int POLL_CLKS  = 6,
    parameter int POLL_MAX   = 5,
    parameter int POLL_BIT   = 7,
    parameter logic [ADDR_W-1:0] UNLOCK_A = 12'h555,
    parameter logic [ADDR_W-1:0] UNLOCK_B = 12'h2AA
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_chip,
    input  logic [NUM_SECT-1:0] req_mask,
    output logic                done,
    output logic                err,
    output logic [1:0]          err_code,
    input  logic                bus_hold,
    output logic                bus_we,
    output logic                bus_re,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W-1:0]   bus_rdata
);

    localparam int IDX_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
    localparam int GAP_W  = $clog2(WIN_CLKS + 1);
    localparam int PIV_W  = $clog2(POLL_CLKS + 1);
    localparam int TRY_W  = $clog2(POLL_MAX + 1);
    localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(WIN_CLKS - 1);
    localparam logic [PIV_W-1:0]  POLL_LAST = PIV_W'(POLL_CLKS - 1);
    localparam logic [TRY_W-1:0]  TRY_LAST  = TRY_W'(POLL_MAX - 1);
    localparam logic [DATA_W-1:0] POLL_MASK = DATA_W'(1) << POLL_BIT;
    localparam logic [DATA_W-1:0] D_UNL1    = DATA_W'(8'hAA);
    localparam logic [DATA_W-1:0] D_UNL2    = DATA_W'(8'h55);
    localparam logic [DATA_W-1:0] D_SETUP   = DATA_W'(8'h80);
    localparam logic [DATA_W-1:0] D_CHIP    = DATA_W'(8'h10);
    localparam logic [DATA_W-1:0] D_SECT    = DATA_W'(8'h30);

    // state register contents
    fec_state_t          state, state_d;
    logic [2:0]          step, step_d;
    logic [NUM_SECT-1:0] pend, pend_d;
    logic                chip_q, chip_d;
    logic [ADDR_W-1:0]   poll_addr, paddr_d;
    fec_err_t            err_q, err_d;

    // datapath links
    logic                wr_req, rd_req, wr_acc, rd_acc, busy;
    logic [ADDR_W-1:0]   req_addr;
    logic [DATA_W-1:0]   req_data;
    logic [IDX_W-1:0]    cur_idx;
    logic [NUM_SECT-1:0] rest;
    logic [ADDR_W-1:0]   cur_base;
    logic [GAP_W-1:0]    gap_cnt;
    logic [PIV_W-1:0]    poll_cnt;
    logic [TRY_W-1:0]    tries_cnt;
    logic                late, status_done;

    fec_sector_pick #(.NUM_SECT(NUM_SECT), .IDX_W(IDX_W)) u_pick (
        .mask (pend),
        .idx  (cur_idx),
        .rest (rest)
    );

    assign cur_base = ADDR_W'(cur_idx) << SECT_SHIFT;

    fec_counter #(.W(GAP_W)) u_gap (
        .clk (clk), .rst_n (rst_n), .clr (wr_acc), .inc (1'b1), .cnt (gap_cnt)
    );

    fec_counter #(.W(PIV_W)) u_pivl (
        .clk (clk), .rst_n (rst_n), .clr (rd_acc), .inc (1'b1), .cnt (poll_cnt)
    );

    fec_counter #(.W(TRY_W)) u_tries (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_IDLE),
        .inc   ((state == ST_POLL_SMP) && !status_done),
        .cnt   (tries_cnt)
    );

    fec_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CLKS(WR_CLKS)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (bus_hold),
        .wr_req    (wr_req),
        .rd_req    (rd_req),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .wr_acc    (wr_acc),
        .rd_acc    (rd_acc),
        .busy      (busy),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    assign late        = (gap_cnt >= GAP_LAST);
    assign status_done = ((bus_rdata & POLL_MASK) != '0);

    // next-state logic
    always_comb begin
        state_d = state;
        step_d  = step;
        pend_d  = pend;
        chip_d  = chip_q;
        paddr_d = poll_addr;
        err_d   = err_q;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    chip_d = req_chip;
                    pend_d = req_mask;
                    step_d = 3'd0;
                    err_d  = FEC_OK;
                    if (req_chip || (req_mask != '0)) begin
                        state_d = ST_PRE;
                    end else begin
                        err_d   = FEC_EMPTY;
                        state_d = ST_FINISH;
                    end
                end
            end
            ST_PRE: begin
                if (wr_acc) begin
                    if (step == 3'd4) state_d = ST_CMD;
                    else              step_d  = step + 3'd1;
                end
            end
            ST_CMD: begin
                if (wr_acc) begin
                    if (chip_q) begin
                        paddr_d = '0;
                        state_d = ST_SETTLE;
                    end else begin
                        paddr_d = cur_base;
                        pend_d  = rest;
                        state_d = (rest == '0) ? ST_SETTLE : ST_MORE;
                    end
                end
            end
            ST_MORE: begin
                if (late) begin
                    err_d   = FEC_LATE;
                    state_d = ST_FINISH;
                end else if (wr_acc) begin
                    pend_d = rest;
                    if (rest == '0) state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (!busy && (chip_q || late)) state_d = ST_POLL_RD;
            end
            ST_POLL_RD: begin
                if (rd_acc) state_d = ST_POLL_SMP;
            end
            ST_POLL_SMP: begin
                if (status_done) begin
                    state_d = ST_FINISH;
                end else if (tries_cnt == TRY_LAST) begin
                    err_d   = FEC_TIMEOUT;
                    state_d = ST_FINISH;
                end else begin
                    state_d = ST_POLL_GAP;
                end
            end
            ST_POLL_GAP: begin
                if (poll_cnt >= POLL_LAST) state_d = ST_POLL_RD;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            step      <= 3'd0;
            pend      <= '0;
            chip_q    <= 1'b0;
            poll_addr <= '0;
            err_q     <= FEC_OK;
        end else begin
            state     <= state_d;
            step      <= step_d;
            pend      <= pend_d;
            chip_q    <= chip_d;
            poll_addr <= paddr_d;
            err_q     <= err_d;
        end
    end

    // outputs and bus requests
    always_comb begin
        req_ready = (state == ST_IDLE);
        done      = (state == ST_FINISH);
        err       = (err_q != FEC_OK);
        err_code  = err_q;
        wr_req    = 1'b0;
        rd_req    = 1'b0;
        req_addr  = '0;
        req_data  = '0;
        unique case (state)
            ST_PRE: begin
                wr_req = 1'b1;
                unique case (step)
                    3'd0:    begin req_addr = UNLOCK_A; req_data = D_UNL1;  end
                    3'd1:    begin req_addr = UNLOCK_B; req_data = D_UNL2;  end
                    3'd2:    begin req_addr = UNLOCK_A; req_data = D_SETUP; end
                    3'd3:    begin req_addr = UNLOCK_A; req_data = D_UNL1;  end
                    default: begin req_addr = UNLOCK_B; req_data = D_UNL2;  end
                endcase
            end
            ST_CMD: begin
                wr_req = 1'b1;
                if (chip_q) begin
                    req_addr = UNLOCK_A;
                    req_data = D_CHIP;
                end else begin
                    req_addr = cur_base;
                    req_data = D_SECT;
                end
            end
            ST_MORE: begin
                wr_req   = !late;
                req_addr = cur_base;
                req_data = D_SECT;
            end
            ST_POLL_RD: begin
                rd_req   = 1'b1;
                req_addr = poll_addr;
            end
            default: begin
                wr_req = 1'b0;
            end
        endcase
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

    AST_SECTOR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_MORE) && wr_acc) |-> (gap_cnt < GAP_LAST)); // R6

    AST_QUIET_BEFORE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !chip_q) |-> (gap_cnt >= GAP_LAST)); // R7

    AST_SILENT_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_POLL_SMP, ST_POLL_GAP}) |-> (!bus_we && !wr_acc)); // R9

    AST_EMPTY_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_FINISH) && (err_q == FEC_EMPTY)) |-> (!bus_we && !bus_re)); // R11

endmodule

// File: tb/flash_erase_ctrl_test.sv
`timescale 1ns/1ps
module flash_erase_ctrl_test;

    localparam int WR   = 4;
    localparam int WIN  = 12;
    localparam int PIV  = 6;
    localparam int PMAX = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_chip = 1'b0;
    logic [3:0] req_mask = '0;
    logic       done, err;
    logic [1:0] err_code;
    logic       bus_hold = 1'b0;
    logic       bus_we, bus_re;
    logic [11:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata = 8'h7F;

    flash_erase_ctrl uut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_chip (req_chip), .req_mask (req_mask), .done (done), .err (err),
        .err_code (err_code), .bus_hold (bus_hold), .bus_we (bus_we), .bus_re (bus_re),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [11:0] wa [0:63];
    logic [7:0]  wd [0:63];
    int          wc [0:63];
    logic [11:0] ra [0:63];
    int          rc [0:63];
    int nw = 0, nr = 0, ndone = 0, done_at = 1, hold_mode = 0, hold_left = 0;
    bit armed_used = 0;
    logic [1:0] got_code;
    logic got_err;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // bus monitor, status model and stall generator
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if ((bus_we || bus_re) && bus_hold)
                chk(0, "R5 strobe after stalled edge", 1, 0);
            if (bus_we && nw < 64) begin
                wa[nw] = bus_addr; wd[nw] = bus_wdata; wc[nw] = cyc; nw++;
            end
            if (bus_re && nr < 64) begin
                ra[nr] = bus_addr; rc[nr] = cyc; nr++;
                bus_rdata = (nr >= done_at) ? 8'h80 : 8'h7F;
            end
            if (done) begin
                ndone++; got_code = err_code; got_err = err;
            end
            if (hold_mode == 1) begin
                bus_hold = (cyc % 3 == 0);
            end else if (hold_mode >= 2) begin
                if (bus_we && bus_wdata == 8'h30 && !armed_used) begin
                    armed_used = 1;
                    hold_left = (hold_mode == 2) ? 15 : 5;
                end
                if (hold_left > 0) begin
                    bus_hold = 1'b1; hold_left--;
                end else begin
                    bus_hold = 1'b0;
                end
            end else begin
                bus_hold = 1'b0;
            end
        end
    end

    task automatic run_job(input bit chip, input logic [3:0] mask, input int dat, input int mode);
        int guard, cnt, exp_nw, k, exp_rd, exp_code, low;
        bit empty, aborted;
        logic [11:0] pre_a [0:4];
        logic [7:0]  pre_d [0:4];
        logic [11:0] exp_pa;
        pre_a[0] = 12'h555; pre_a[1] = 12'h2AA; pre_a[2] = 12'h555; pre_a[3] = 12'h555; pre_a[4] = 12'h2AA;
        pre_d[0] = 8'hAA;   pre_d[1] = 8'h55;   pre_d[2] = 8'h80;   pre_d[3] = 8'hAA;   pre_d[4] = 8'h55;
        nw = 0; nr = 0; ndone = 0; done_at = dat; hold_left = 0; armed_used = 0;
        bus_rdata = (dat <= 0) ? 8'h80 : 8'h7F;
        hold_mode = mode;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready when idle", int'(req_ready), 1);
        req_valid = 1'b1; req_chip = chip; req_mask = mask;
        @(negedge clk);
        req_valid = 1'b0; req_mask = ~mask;
        chk(req_ready == 1'b0, "R1 ready drops after accept", int'(req_ready), 0);
        guard = 0;
        while (ndone == 0 && guard < 3000) begin
            @(negedge clk); guard++;
        end
        chk(guard < 3000, "R12 job finished (watchdog)", guard, 0);
        repeat (4) @(negedge clk);
        hold_mode = 0;
        chk(ndone == 1, "R12 single done pulse", ndone, 1);
        chk(got_err == (got_code != 2'd0), "R12 err matches code", int'(got_err), int'(got_code != 2'd0));
        cnt = $countones(mask);
        empty = !chip && (mask == 4'd0);
        if (empty) begin
            chk(nw == 0 && nr == 0, "R11 empty job no bus cycles", nw + nr, 0);
            chk(got_code == 2'd3, "R11 empty job code", int'(got_code), 3);
            return;
        end
        aborted = (mode == 2) && !chip && (cnt >= 2);
        exp_nw = aborted ? 6 : (chip ? 6 : 5 + cnt);
        chk(nw == exp_nw, "R3 write count", nw, exp_nw);
        for (int i = 0; i < 5; i++)
            chk(wa[i] == pre_a[i] && wd[i] == pre_d[i], "R2 preamble write",
                int'({wa[i], wd[i]}), int'({pre_a[i], pre_d[i]}));
        low = 0;
        for (int s = 3; s >= 0; s--) if (mask[s]) low = s;
        if (chip) begin
            chk(wa[5] == 12'h555 && wd[5] == 8'h10, "R8 chip command",
                int'({wa[5], wd[5]}), int'({12'h555, 8'h10}));
            exp_pa = 12'h000;
        end else begin
            k = 5;
            for (int s = 0; s < 4; s++) begin
                if (mask[s] && k < nw) begin
                    chk(wa[k] == 12'(s << 10) && wd[k] == 8'h30, "R3 sector command order",
                        int'({wa[k], wd[k]}), int'({12'(s << 10), 8'h30}));
                    k++;
                end
            end
            exp_pa = 12'(low << 10);
        end
        for (int i = 1; i < nw; i++) begin
            if (mode == 0) chk(wc[i] - wc[i-1] == WR, "R4 strobe spacing exact", wc[i] - wc[i-1], WR);
            else           chk(wc[i] - wc[i-1] >= WR, "R4 strobe spacing min", wc[i] - wc[i-1], WR);
            if (i > 5)     chk(wc[i] - wc[i-1] < WIN, "R6 sector gap inside window", wc[i] - wc[i-1], WIN - 1);
        end
        if (aborted) begin
            chk(got_code == 2'd1, "R6 window abort code", int'(got_code), 1);
            chk(nr == 0, "R6 no reads after abort", nr, 0);
            return;
        end
        exp_rd   = (dat <= PMAX) ? dat : PMAX;
        exp_code = (dat <= PMAX) ? 0 : 2;
        chk(nr == exp_rd, "R10 read count", nr, exp_rd);
        chk(int'(got_code) == exp_code, "R9 completion code", int'(got_code), exp_code);
        for (int i = 0; i < nr; i++)
            chk(ra[i] == exp_pa, "R9 poll address", int'(ra[i]), int'(exp_pa));
        for (int i = 1; i < nr; i++)
            chk(rc[i] - rc[i-1] >= PIV, "R9 poll spacing", rc[i] - rc[i-1], PIV);
        if (!chip && nr > 0)
            chk(rc[0] - wc[nw-1] >= WIN, "R7 quiet before first poll", rc[0] - wc[nw-1], WIN);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && bus_we == 1'b0 && bus_re == 1'b0, "R1 reset state bus idle",
            int'({req_ready, bus_we, bus_re}), 4);
        chk(done == 1'b0 && err == 1'b0 && err_code == 2'd0, "R12 reset state flags",
            int'({done, err, err_code}), 0);
        for (int m = 0; m < 16; m++) run_job(1'b0, 4'(m), 1 + (m % 3), m % 2);
        run_job(1'b1, 4'b0000, 2, 0);
        run_job(1'b1, 4'b1010, 3, 1);
        run_job(1'b0, 4'b0110, 99, 0);
        run_job(1'b0, 4'b0101, 1, 2);
        run_job(1'b0, 4'b1101, 2, 3);
        run_job(1'b0, 4'b1000, 2, 2);
        run_job(1'b0, 4'b1111, PMAX, 0);
        run_job(1'b0, 4'b0011, PMAX + 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule